// File: doc/BRIEF.md
# Cascadable TDM Audio Frame Shifter

The block is the serial data engine of one converter node on a daisy-chained, time-division-multiplexed audio link. Each node holds a frame register of SLOTS words of SLOT_W bits, 256 bits by default. At a frame boundary the node loads its capture words in parallel and starts shifting them, MSB first, out of `sdo_o` toward the upstream side (the DSP). Bits arriving on `sdi_i` from the downstream side fill in behind them. Over one frame of NODES x 256 bit clocks the downstream capture data passes through the node first and playback data from the DSP follows it. When the frame ends, the last 256 bits received are presented as the playback words.

A chain is built by wiring each node's `sdi_i` to the `sdo_o` of the node below it. The DSP's transmit line drives `sdi_i` of the last node, and the DSP's receive line takes `sdo_o` of the first node. The first node runs as master. It divides the common master clock into the bit clock and produces the frame sync for the DSP and for every slave. Slaves follow those two signals and drive their own clock outputs low. All nodes share one master clock and one reset, so their frames stay aligned.

Top module: `tdm_cascade_node`

## Requirements
- R1: While reset is held and right after it, `sdo_o`, `pb_o`, `frame_o` and `bclk_o` are 0. A master drives `fsync_o` at 1, so the first bit period is a sync period. A slave drives `fsync_o` at 0.
- R2: In master mode `bclk_o` has a period of DIV master clocks and is high for the second half of that period (DIV/2 clocks).
- R3: In master mode `fsync_o` is high for exactly one bit period in every NODES*SLOTS*SLOT_W bit periods. That period is the one just before the first MSB of each frame.
- R4: In slave mode `bclk_o` and `fsync_o` stay at 0. The node takes its timing from `bclk_i` and `fsync_i`.
- R5: `sdo_o` changes only after a falling bit-clock edge. `sdi_i` is sampled on the rising edge.
- R6: At a boundary the node loads `cap_i`. Slot k occupies `cap_i[FW-1-SLOT_W*k -: SLOT_W]` (k = 0..7 in the order L1, L2, L3, L4, R1, R2, R3, R4). Slot 0 goes out first, MSB first, in the bit period right after the sync period.
- R7: In a two-node chain the DSP receives 16 words per frame: the master's 8 slots, then the slave's 8 slots, each in slot order.
- R8: Of the 16 words the DSP sends in a frame, the master presents words 0..7 on `pb_o` and the slave presents words 8..15, each in the same slot layout as `cap_i`. `pb_o` holds until the next boundary.
- R9: `frame_o` pulses for one master clock at each boundary, in the cycle in which `pb_o` first shows the new words. Load and unload happen at the same boundary, so no bit is lost between back-to-back frames.
- R10: Changes on `cap_i` away from the boundary have no effect. Only the value present at the boundary reaches the DSP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = generate bit clock and frame sync, 0 = follow them |
| bclk_i | input | 1 | Bit clock from the master (slave mode) |
| fsync_i | input | 1 | Frame sync from the master (slave mode) |
| sdi_i | input | 1 | Serial data from downstream |
| cap_i | input | SLOTS*SLOT_W | Capture words, slot 0 in the top bits |
| bclk_o | output | 1 | Generated bit clock (0 in slave mode) |
| fsync_o | output | 1 | Generated frame sync (0 in slave mode) |
| sdo_o | output | 1 | Serial data toward upstream |
| pb_o | output | SLOTS*SLOT_W | Playback words, slot 0 in the top bits |
| frame_o | output | 1 | One-cycle boundary strobe |

## Verification
Three actions fall on the same falling bit-clock edge at the boundary: the 512th shift, the parallel load of fresh capture words and the unload of the playback words. The bench provokes this by running back-to-back frames with distinct capture and playback patterns on each frame, through a two-node chain and a DSP model. The boundary is judged correct if three things hold: the last DSP bit lands as the LSB of the slave's final playback word, the first bit of the next frame is the master's new L1 MSB, and `pb_o` changes only in the cycles where `frame_o` is high. Capture inputs are also disturbed mid-frame, to show that only the value present at the boundary is sent.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  // bit-clock events in the master clock domain
  typedef struct packed {
    logic rise;
    logic fall;
    logic fs;
  } bit_ev_t;
endpackage

// File: rtl/tdm_clk_gen.sv
`timescale 1ns/1ps
module tdm_clk_gen #(
  parameter int DIV        = 8,
  parameter int FRAME_BITS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic bclk_o,
  output logic fs_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW   = $clog2(FRAME_BITS);

  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q, bit_nxt;
  logic          bclk_q, fs_q;

  assign rise_o  = en_i && (div_q == DW'(HALF - 1));
  assign fall_o  = en_i && (div_q == DW'(DIV - 1));
  assign bit_nxt = (bit_q == BW'(FRAME_BITS - 1)) ? '0 : bit_q + 1'b1;

  // reset lands in the sync period so the first fall is a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
      fs_q   <= 1'b1;
      bit_q  <= BW'(FRAME_BITS - 1);
    end else if (en_i) begin
      div_q <= fall_o ? '0 : div_q + 1'b1;
      if (rise_o) bclk_q <= 1'b1;
      if (fall_o) begin
        bclk_q <= 1'b0;
        bit_q  <= bit_nxt;
        fs_q   <= (bit_nxt == BW'(FRAME_BITS - 1));
      end
    end
  end

  assign bclk_o = bclk_q;
  assign fs_o   = fs_q;

  p_bclk_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (bclk_q == (div_q >= DW'(HALF))));

  p_fs_last_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> (bit_q == BW'(FRAME_BITS - 1)));
endmodule

// File: rtl/tdm_edge_sel.sv
`timescale 1ns/1ps
module tdm_edge_sel
  import tdm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    master_i,
  input  logic    g_rise_i,
  input  logic    g_fall_i,
  input  logic    g_fs_i,
  input  logic    bclk_i,
  input  logic    fsync_i,
  output bit_ev_t ev_o
);
  logic bclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_d <= 1'b0;
    else         bclk_d <= bclk_i;
  end

  // slave events trail the master's by one clock
  always_comb begin
    ev_o.rise = master_i ? g_rise_i : (bclk_i & ~bclk_d);
    ev_o.fall = master_i ? g_fall_i : (~bclk_i & bclk_d);
    ev_o.fs   = master_i ? g_fs_i   : fsync_i;
  end

  p_edge_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_o.rise && ev_o.fall));
endmodule

// File: rtl/tdm_frame_shifter.sv
`timescale 1ns/1ps
module tdm_frame_shifter
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  bit_ev_t                   ev_i,
  input  logic                      sdi_i,
  input  logic [SLOT_W*SLOTS-1:0]   cap_i,
  output logic                      sdo_o,
  output logic [SLOT_W*SLOTS-1:0]   pb_o,
  output logic                      frame_o
);
  localparam int FW = SLOT_W * SLOTS;

  logic [FW-1:0] sr_q, pb_q, shifted;
  logic          rx_q, bnd_q, frm_q;

  assign shifted = {sr_q[FW-2:0], rx_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      pb_q  <= '0;
      rx_q  <= 1'b0;
      bnd_q <= 1'b0;
      frm_q <= 1'b0;
    end else begin
      frm_q <= 1'b0;
      if (ev_i.rise) begin
        rx_q  <= sdi_i;
        bnd_q <= ev_i.fs;
      end
      if (ev_i.fall) begin
        if (bnd_q) begin
          // final shift goes to playback, fresh capture takes its place
          pb_q  <= shifted;
          sr_q  <= cap_i;
          frm_q <= 1'b1;
        end else begin
          sr_q <= shifted;
        end
      end
    end
  end

  assign sdo_o   = sr_q[FW-1];
  assign pb_o    = pb_q;
  assign frame_o = frm_q;

  p_sdo_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.fall |=> $stable(sr_q[FW-1]));

  p_load_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.fall && bnd_q) |=> (sr_q == $past(cap_i)));

  p_pb_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_i.fall && bnd_q) |=> $stable(pb_q));

  p_frame_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q |=> !frm_q);
endmodule

// File: rtl/tdm_cascade_node.sv
`timescale 1ns/1ps
module tdm_cascade_node
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8,
  parameter int NODES  = 2,
  parameter int DIV    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    master_i,
  input  logic                    bclk_i,
  input  logic                    fsync_i,
  input  logic                    sdi_i,
  input  logic [SLOT_W*SLOTS-1:0] cap_i,
  output logic                    bclk_o,
  output logic                    fsync_o,
  output logic                    sdo_o,
  output logic [SLOT_W*SLOTS-1:0] pb_o,
  output logic                    frame_o
);
  localparam int FRAME_BITS = NODES * SLOTS * SLOT_W;

  logic    g_bclk, g_fs, g_rise, g_fall;
  bit_ev_t ev;

  tdm_clk_gen #(.DIV(DIV), .FRAME_BITS(FRAME_BITS)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (master_i),
    .bclk_o (g_bclk),
    .fs_o   (g_fs),
    .rise_o (g_rise),
    .fall_o (g_fall)
  );

  tdm_edge_sel u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .g_rise_i (g_rise),
    .g_fall_i (g_fall),
    .g_fs_i   (g_fs),
    .bclk_i   (bclk_i),
    .fsync_i  (fsync_i),
    .ev_o     (ev)
  );

  tdm_frame_shifter #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) u_shf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .sdi_i   (sdi_i),
    .cap_i   (cap_i),
    .sdo_o   (sdo_o),
    .pb_o    (pb_o),
    .frame_o (frame_o)
  );

  assign bclk_o  = master_i & g_bclk;
  assign fsync_o = master_i & g_fs;

  p_slave_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!bclk_o && !fsync_o));
endmodule

// File: tb/tdm_cascade_node_test.sv
`timescale 1ns/1ps
module tdm_cascade_node_test;
  localparam int SLOT_W = 32, SLOTS = 8, NODES = 2, DIV = 4, HALF = DIV / 2;
  localparam int FW = SLOT_W * SLOTS, FB = FW * NODES, NW = SLOTS * NODES;
  localparam int NV = 5;
  // {capture seed, playback seed}; expected words derive from the seeds
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'hA5A5_5A5A, 32'h1234_5678},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'h8000_0001, 32'h7FFF_FFFE},
    {32'hDEAD_BEEF, 32'hC0DE_F00D}
  };

  logic clk = 1'b0, rst_n = 1'b0, dt = 1'b0;
  always #4 clk = ~clk;

  logic [FW-1:0] cap_m, cap_s, pb_m, pb_s;
  logic m_bclk, m_fs, m_sdo, m_frm, s_bclk, s_fs, s_sdo, s_frm;

  tdm_cascade_node #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .NODES(NODES), .DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b1), .bclk_i(1'b0), .fsync_i(1'b0),
    .sdi_i(s_sdo), .cap_i(cap_m), .bclk_o(m_bclk), .fsync_o(m_fs),
    .sdo_o(m_sdo), .pb_o(pb_m), .frame_o(m_frm));

  tdm_cascade_node #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .NODES(NODES), .DIV(DIV)) uut_slv (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b0), .bclk_i(m_bclk), .fsync_i(m_fs),
    .sdi_i(dt), .cap_i(cap_s), .bclk_o(s_bclk), .fsync_o(s_fs),
    .sdo_o(s_sdo), .pb_o(pb_s), .frame_o(s_frm));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nf_m = 0, nf_s = 0, pb_bad = 0;
  logic [FW-1:0] pb_m_d = '0, pb_s_d = '0;
  logic [FB-1:0] prev_tx = '0;

  always @(posedge clk) cyc++;

  // R9: playback may only change in a frame_o cycle
  always @(negedge clk) if (rst_n) begin
    if (m_frm) nf_m++;
    if (s_frm) nf_s++;
    if (pb_m !== pb_m_d && !m_frm) pb_bad++;
    if (pb_s !== pb_s_d && !s_frm) pb_bad++;
    pb_m_d = pb_m;
    pb_s_d = pb_s;
  end

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [SLOT_W-1:0] wgen(input logic [31:0] seed, input int k);
    return seed ^ (32'h0101_0101 * 32'(k + 1));
  endfunction

  function automatic logic [FW-1:0] node_vec(input logic [31:0] seed, input int n);
    logic [FW-1:0] v;
    for (int k = 0; k < SLOTS; k++) v[FW-1-SLOT_W*k -: SLOT_W] = wgen(seed, n * SLOTS + k);
    return v;
  endfunction

  task automatic run_frame(input int f);
    logic [FB-1:0] tx, rx;
    logic [31:0] cs, ps;
    logic s1;
    int fs_bad = 0, hold_bad = 0;
    {cs, ps} = VEC[f];
    tx = {node_vec(ps, 0), node_vec(ps, 1)};
    rx = '0;
    for (int j = 0; j < FB; j++) begin
      #1 dt = tx[FB-1-j];
      if (f < NV - 1 && j == 100) begin  // R10: junk mid-frame
        cap_m = node_vec(~VEC[f+1][63:32], 0);
        cap_s = node_vec(~VEC[f+1][63:32], 1);
      end
      if (f < NV - 1 && j == 300) begin
        cap_m = node_vec(VEC[f+1][63:32], 0);
        cap_s = node_vec(VEC[f+1][63:32], 1);
      end
      @(posedge m_bclk); #2;
      rx[FB-1-j] = m_sdo;
      if (m_fs !== (j == FB - 1)) fs_bad++;
      if (j == 0) begin
        for (int k = 0; k < SLOTS; k++) begin
          chk(pb_m[FW-1-SLOT_W*k -: SLOT_W] === prev_tx[FB-1-SLOT_W*k -: SLOT_W], "R8 master playback",
              FW'(pb_m[FW-1-SLOT_W*k -: SLOT_W]), FW'(prev_tx[FB-1-SLOT_W*k -: SLOT_W]));
          chk(pb_s[FW-1-SLOT_W*k -: SLOT_W] === prev_tx[FW-1-SLOT_W*k -: SLOT_W], "R8 slave playback",
              FW'(pb_s[FW-1-SLOT_W*k -: SLOT_W]), FW'(prev_tx[FW-1-SLOT_W*k -: SLOT_W]));
        end
      end
      if (j == FB - 1) chk(s_bclk === 1'b0 && s_fs === 1'b0, "R4 slave outputs quiet",
                           FW'({s_bclk, s_fs}), '0);
      s1 = m_sdo;
      #(HALF * 8 - 4);
      if (m_sdo !== s1) hold_bad++;
      @(negedge m_bclk);
    end
    for (int i = 0; i < NW; i++)
      chk(rx[FB-1-SLOT_W*i -: SLOT_W] === wgen(cs, i), (i < SLOTS) ? "R6 master slot order" : "R7 chained slave slot",
          FW'(rx[FB-1-SLOT_W*i -: SLOT_W]), FW'(wgen(cs, i)));
    chk(fs_bad == 0, "R3 sync position", FW'(fs_bad), '0);
    chk(hold_bad == 0, "R5 sdo held through high phase", FW'(hold_bad), '0);
    prev_tx = tx;
  endtask

  initial begin
    int t0, t1, t2;
    cap_m = node_vec(VEC[0][63:32], 0);
    cap_s = node_vec(VEC[0][63:32], 1);
    repeat (3) @(posedge clk);
    #2;
    chk(m_sdo === 1'b0 && s_sdo === 1'b0, "R1 sdo reset", FW'({m_sdo, s_sdo}), '0);
    chk(pb_m === '0 && pb_s === '0, "R1 playback reset", pb_m | pb_s, '0);
    chk(m_bclk === 1'b0 && m_frm === 1'b0 && s_frm === 1'b0, "R1 clock/strobe reset",
        FW'({m_bclk, m_frm, s_frm}), '0);
    chk(m_fs === 1'b1, "R1 master sync high", FW'(m_fs), FW'(1));
    chk(s_fs === 1'b0 && s_bclk === 1'b0, "R1 slave outputs", FW'({s_fs, s_bclk}), '0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge m_bclk);  // first boundary
    for (int f = 0; f < NV; f++) run_frame(f);
    @(posedge m_bclk); #2;
    chk(pb_m === prev_tx[FB-1 -: FW], "R8 master last frame", pb_m, prev_tx[FB-1 -: FW]);
    chk(pb_s === prev_tx[FW-1:0], "R8 slave last frame", pb_s, prev_tx[FW-1:0]);
    chk(nf_m == NV + 1, "R9 master boundary count", FW'(nf_m), FW'(NV + 1));
    chk(nf_s == NV + 1, "R9 slave boundary count", FW'(nf_s), FW'(NV + 1));
    chk(pb_bad == 0, "R9 playback only with strobe", FW'(pb_bad), '0);
    @(posedge m_bclk); #1 t0 = cyc;
    @(negedge m_bclk); #1 t1 = cyc;
    @(posedge m_bclk); #1 t2 = cyc;
    chk(t2 - t0 == DIV, "R2 bit clock period", FW'(t2 - t0), FW'(DIV));
    chk(t1 - t0 == HALF, "R2 bit clock high time", FW'(t1 - t0), FW'(HALF));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule